// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Latched Reload

This block generates six independent pulse-width-modulated outputs from one clock. Software reaches it over a flat 32-bit register bus: a byte address, a write strobe, write data and a combinational read-data return. Each channel owns a 32-byte window holding a control word, a period value and a duty value. Period and duty writes land in shadow copies only. They move into the counting registers when software raises a reload bit in the control word.

Each channel runs a two-state machine. In `CH_IDLE` the output holds a programmable rest level. The LAUNCH transition moves it to `CH_RUN` when software sets the self-clearing start bit and the period that would be in effect is non-zero. In `CH_RUN` the counter steps from 0 to period−1, and the output is in its active phase while the count is below the duty value. At the last count the channel either WRAPs back to 0 (continuous mode), or it HALTs into `CH_IDLE` when one-shot mode is selected or the reloaded period is zero. A reload that is requested while the channel runs is held until the next period end. A reload that is requested while the channel is idle applies at once.

Top module: `pwm_multi`

## Requirements
- R1: Channel c (0..5) occupies byte addresses c·0x20 to c·0x20+0x1F, with control at offset 0x00, period at 0x08 and duty at 0x0C. Reading period or duty returns the last value written (the shadow copy).
- R2: Control reads return only bit 2 (reload), bit 5 (continuous), bit 8 (polarity) and bit 9 (rest level); all other bits read 0, bit 0 (start) always reads 0. Any other offset, and any channel index of 6 or above, reads 0.
- R3: Writing period or duty does not change the output until a reload is applied.
- R4: A reload is requested only when a control write sets bit 2 while the stored bit 2 is 0; writing 1 again while it is already 1 has no effect.
- R5: A reload requested in `CH_IDLE` copies the shadows at that write; one requested in `CH_RUN` is applied at the next period end, so the period in progress is not disturbed.
- R6: A control write with bit 0 set in `CH_IDLE` starts counting from 0 on the next cycle; a start written during `CH_RUN` is ignored; one period lasts exactly `period` cycles.
- R7: With bit 5 = 1 the counter wraps and repeats; with bit 5 = 0 the channel returns to `CH_IDLE` after one period.
- R8: While running, the output equals bit 8 during the active phase (count < duty) and its inverse otherwise.
- R9: In `CH_IDLE` the output equals bit 9; after reset all outputs are 0 and all registers read 0.
- R10: A channel never runs with a zero period: a start is refused when the effective period is 0, and a zero period reloaded at a period end stops the channel.
- R11: A duty of 0 gives a constant inactive level; a duty greater than or equal to the period gives a constant active level.
- R12: Writes to one channel never affect any other channel's registers or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 6 | One PWM output per channel |

## Verification
A wrong count, a lost reload or a wrong state shows up on `pwm_out` within one period of the channel. The bench keeps periods short (at most 12 cycles), so such a fault is exposed within a dozen cycles. A pending reload that is applied too early or too late changes the width of the current pulse, so every output bit is compared with a cycle-accurate model on every cycle. Errors in the shadow registers or in address decoding appear at once on `bus_rdata`, and they are checked by readbacks that are mixed into the random traffic.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int CTL_START = 0;
    localparam int CTL_UPD   = 2;
    localparam int CTL_CONT  = 5;
    localparam int CTL_POL   = 8;
    localparam int CTL_REST  = 9;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_CTRL,
        REG_PER,
        REG_DUTY
    } reg_kind_e;

    typedef enum logic {
        CH_IDLE,
        CH_RUN
    } ch_state_e;
endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_kind_e         kind
);
    localparam int IDX_W = ADDR_W - 5;

    logic [IDX_W-1:0] idx;
    logic [4:0]       off;

    assign idx = addr[ADDR_W-1:5];
    assign off = addr[4:0];

    always_comb begin
        unique case (off)
            5'h00:   kind = REG_CTRL;
            5'h08:   kind = REG_PER;
            5'h0C:   kind = REG_DUTY;
            default: kind = REG_NONE;
        endcase
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        assign ch_hit[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_per,
    input  logic              wr_duty,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] per_rd,
    output logic [DATA_W-1:0] duty_rd,
    output logic              pwm_o
);
    ch_state_e        state_q, state_d;
    logic             cfg_q, cont_q, pol_q, rest_q, pend_q;
    logic [CNT_W-1:0] sh_per_q, sh_dut_q, act_per_q, act_dut_q, cnt_q;

    logic             upd_rise, start_req, at_end, idle_load, edge_load;
    logic [CNT_W-1:0] per_next;

    assign upd_rise  = wr_ctrl && wdata[CTL_UPD] && !cfg_q;
    assign start_req = wr_ctrl && wdata[CTL_START];
    assign at_end    = (state_q == CH_RUN) && (cnt_q == act_per_q - CNT_W'(1));
    assign idle_load = (state_q == CH_IDLE) && (upd_rise || pend_q);
    assign edge_load = at_end && pend_q;
    assign per_next  = (idle_load || edge_load) ? sh_per_q : act_per_q;

    // next-state logic: LAUNCH, WRAP, HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (start_req && per_next != '0) state_d = CH_RUN;
            CH_RUN:  if (at_end && (!cont_q || per_next == '0)) state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= 1'b0;
            cont_q    <= 1'b0;
            pol_q     <= 1'b0;
            rest_q    <= 1'b0;
            pend_q    <= 1'b0;
            sh_per_q  <= '0;
            sh_dut_q  <= '0;
            act_per_q <= '0;
            act_dut_q <= '0;
            cnt_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_q  <= wdata[CTL_UPD];
                cont_q <= wdata[CTL_CONT];
                pol_q  <= wdata[CTL_POL];
                rest_q <= wdata[CTL_REST];
            end
            if (wr_per)  sh_per_q <= wdata[CNT_W-1:0];
            if (wr_duty) sh_dut_q <= wdata[CNT_W-1:0];
            if (idle_load || edge_load) begin
                act_per_q <= sh_per_q;
                act_dut_q <= sh_dut_q;
            end
            if (state_q == CH_RUN) pend_q <= upd_rise ? 1'b1 : (at_end ? 1'b0 : pend_q);
            else                   pend_q <= 1'b0;
            cnt_q <= (state_q == CH_RUN && !at_end) ? cnt_q + CNT_W'(1) : '0;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            CH_IDLE: pwm_o = rest_q;
            CH_RUN:  pwm_o = (cnt_q < act_dut_q) ? pol_q : !pol_q;
        endcase
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[CTL_UPD]  = cfg_q;
        ctrl_rd[CTL_CONT] = cont_q;
        ctrl_rd[CTL_POL]  = pol_q;
        ctrl_rd[CTL_REST] = rest_q;
    end
    assign per_rd  = DATA_W'(sh_per_q);
    assign duty_rd = DATA_W'(sh_dut_q);

    // R10
    zero_period_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CH_RUN |-> act_per_q != '0);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && !at_end) |=> (state_q == CH_RUN && cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && !at_end) |=> ($stable(act_per_q) && $stable(act_dut_q)));

    // R7
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !cont_q) |=> state_q == CH_IDLE);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [5:0]        pwm_out
);
    logic [NUM_CH-1:0] ch_hit;
    reg_kind_e         kind;
    logic [DATA_W-1:0] ctrl_rd [NUM_CH];
    logic [DATA_W-1:0] per_rd  [NUM_CH];
    logic [DATA_W-1:0] duty_rd [NUM_CH];

    pwm_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
        .addr   (bus_addr),
        .ch_hit (ch_hit),
        .kind   (kind)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) ch_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (bus_we && ch_hit[g] && kind == REG_CTRL),
            .wr_per  (bus_we && ch_hit[g] && kind == REG_PER),
            .wr_duty (bus_we && ch_hit[g] && kind == REG_DUTY),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_rd[g]),
            .per_rd  (per_rd[g]),
            .duty_rd (duty_rd[g]),
            .pwm_o   (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
                unique case (kind)
                    REG_CTRL: bus_rdata = ctrl_rd[i];
                    REG_PER:  bus_rdata = per_rd[i];
                    REG_DUTY: bus_rdata = duty_rd[i];
                    REG_NONE: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R9";

    // reference model state
    logic [31:0] m_sper [6], m_sdut [6], m_aper [6], m_adut [6], m_cnt [6];
    logic        m_cfg [6], m_cont [6], m_pol [6], m_rest [6], m_pend [6], m_run [6];

    always #2.5 clk = ~clk;

    pwm_multi dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [5:0] exp_out();
        logic [5:0] v;
        for (int c = 0; c < 6; c++)
            v[c] = m_run[c] ? ((m_cnt[c] < m_adut[c]) ? m_pol[c] : !m_pol[c]) : m_rest[c];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int c = int'(a[7:5]);
        if (c >= 6) return 32'h0;
        case (a[4:0])
            5'h00:   return (32'(m_cfg[c]) << 2) | (32'(m_cont[c]) << 5) |
                            (32'(m_pol[c]) << 8) | (32'(m_rest[c]) << 9);
            5'h08:   return m_sper[c];
            5'h0C:   return m_sdut[c];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 6; c++) begin
            m_sper[c] = 0; m_sdut[c] = 0; m_aper[c] = 0; m_adut[c] = 0; m_cnt[c] = 0;
            m_cfg[c] = 0; m_cont[c] = 0; m_pol[c] = 0; m_rest[c] = 0; m_pend[c] = 0; m_run[c] = 0;
        end
    endtask

    task automatic model_step();
        for (int c = 0; c < 6; c++) begin
            logic wc, wp, wd, rise, st;
            wc   = bus_we && bus_addr == 8'(c * 32);
            wp   = bus_we && bus_addr == 8'(c * 32 + 8);
            wd   = bus_we && bus_addr == 8'(c * 32 + 12);
            rise = wc && bus_wdata[2] && !m_cfg[c];
            st   = wc && bus_wdata[0];
            if (m_run[c]) begin
                if (m_cnt[c] == m_aper[c] - 1) begin
                    if (m_pend[c]) begin m_aper[c] = m_sper[c]; m_adut[c] = m_sdut[c]; end
                    m_pend[c] = 0;
                    if (!m_cont[c] || m_aper[c] == 0) m_run[c] = 0;
                    m_cnt[c] = 0;
                end else m_cnt[c] = m_cnt[c] + 1;
                if (rise) m_pend[c] = 1;
            end else begin
                if (rise || m_pend[c]) begin m_aper[c] = m_sper[c]; m_adut[c] = m_sdut[c]; end
                m_pend[c] = 0;
                if (st && m_aper[c] != 0) begin m_run[c] = 1; m_cnt[c] = 0; end
            end
            if (wc) begin
                m_cfg[c] = bus_wdata[2]; m_cont[c] = bus_wdata[5];
                m_pol[c] = bus_wdata[8]; m_rest[c] = bus_wdata[9];
            end
            if (wp) m_sper[c] = bus_wdata;
            if (wd) m_sdut[c] = bus_wdata;
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    // per-cycle output comparison, tagged with the requirement under test
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [5:0] e;
            e = exp_out();
            checks++;
            if (pwm_out !== e) begin
                fails++;
                $display("FAIL %s pwm_out=%b expected=%b at %0t", cur_req, pwm_out, e, $time);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a;
        #1;
        e = exp_read(a);
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R9";
        idle_cycles(2);
        rd(8'h00, "R9");
        rd(8'h08, "R9");

        cur_req = "R1";
        wr(8'h48, 32'h1234_5678);
        wr(8'h4C, 32'h0000_ABCD);
        rd(8'h48, "R1");
        rd(8'h4C, "R1");

        cur_req = "R2";
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, "R2");
        rd(8'hC0, "R2");
        rd(8'h04, "R2");
        rd(8'h10, "R2");
        wr(8'h60, 32'h0);

        cur_req = "R6";
        wr(8'h08, 32'd5);
        wr(8'h0C, 32'd2);
        wr(8'h00, 32'h124);
        wr(8'h00, 32'h125);
        idle_cycles(12);

        cur_req = "R3";
        wr(8'h0C, 32'd4);
        idle_cycles(12);

        cur_req = "R4";
        wr(8'h00, 32'h125);
        idle_cycles(12);

        cur_req = "R5";
        wr(8'h00, 32'h120);
        wr(8'h00, 32'h124);
        idle_cycles(12);

        cur_req = "R8";
        wr(8'h28, 32'd4);
        wr(8'h2C, 32'd1);
        wr(8'h20, 32'h024);
        wr(8'h20, 32'h025);
        idle_cycles(10);

        cur_req = "R7";
        wr(8'h88, 32'd3);
        wr(8'h8C, 32'd1);
        wr(8'h80, 32'h304);
        wr(8'h80, 32'h305);
        idle_cycles(8);

        cur_req = "R10";
        wr(8'hA0, 32'h125);
        idle_cycles(4);
        wr(8'h28, 32'd0);
        wr(8'h20, 32'h020);
        wr(8'h20, 32'h024);
        idle_cycles(10);

        cur_req = "R11";
        wr(8'h00, 32'h120);
        wr(8'h0C, 32'd0);
        wr(8'h00, 32'h124);
        idle_cycles(12);
        wr(8'h00, 32'h120);
        wr(8'h0C, 32'd9);
        wr(8'h00, 32'h124);
        idle_cycles(12);

        cur_req = "R12";
        for (int i = 0; i < 600; i++) begin
            int c, k;
            c = int'($urandom % 6);
            k = int'($urandom % 5);
            case (k)
                0, 1: wr(8'(c * 32), $urandom);
                2:    wr(8'(c * 32 + 8), $urandom % 13);
                3:    wr(8'(c * 32 + 12), $urandom % 15);
                default: rd(8'($urandom % 256), "R12");
            endcase
            idle_cycles(int'($urandom % 8));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule